// File: doc/BRIEF.md
# Wiper and Initial-Value Shadow Controller

This block sits behind a serial-bus register slave and holds the tap settings of four potentiometer channels. Each channel has a volatile tap register, which drives a 7-bit wiper output. It also has a start-up value that lives in a slow persistent store. The controller keeps a flop copy of each stored start-up value so that it can be read back without going to the store.

After reset the controller fetches the four stored values from the store, one channel at a time, and places each one in both the tap register and the copy. Until this fetch has finished, every wiper output sits at mid-scale. A write to a start-up address moves the wiper at once, but the write to the store waits. It is held as the single pending commit of the current bus transaction and only begins when the bus signals STOP. The store write then occupies a fixed busy window, which is counted in clock cycles. A write-in-progress flag, visible in a control register, is raised for the length of that window.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset the block fetches channels 0, 1, 2 and 3 in that order, one per cycle in which `mem_done_i` is high while a fetch is requested (`mem_req_o`=1, `mem_we_o`=0). Each fetched value is written to both that channel's tap register and its start-up copy.
- R2: Until the fourth fetch has completed, every wiper output reads 64 (mid-scale). From the next cycle on, each wiper output shows its tap register.
- R3: A bus write to address 0..3 sets the tap of channel `addr` to `wr_data_i[6:0]`, visible on the wiper output one cycle later. This also holds while a store write is busy.
- R4: An accepted bus write to address 4..7 sets the tap of channel `addr-4` one cycle later and records a pending commit. Reading that address still returns the old stored value.
- R5: A pending commit reaches the store only after `stop_i` is pulsed. That cycle starts one store request (`mem_we_o`=1) carrying the pending channel and value. A STOP with nothing pending has no effect.
- R6: Control register address 8 reads 0x20 (bit 5 set) while a store write is busy and 0 otherwise. The busy window lasts exactly BUSY_CYCLES cycles from the edge that samples the STOP, provided the store acknowledges within that window.
- R7: A write to address 4..7 has no effect on taps, copies or pending state in three cases: while busy, while a commit is already pending in the same transaction, or while the start-up fetch is running.
- R8: While busy, reading a start-up address returns the value stored before the commit. Once busy ends, it returns the committed value.
- R9: A committed value is held by the store and comes back on the wiper output after the next reset.
- R10: Writes to address 8 and to addresses 9..15 change nothing. Addresses 9..15 read 0, and every bit of address 8 other than bit 5 reads 0.
- R11: A bus write of any kind during the start-up fetch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en_i | input | 1 | Register write strobe from the bus slave |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| stop_i | input | 1 | One-cycle pulse on bus STOP |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| mem_req_o | output | 1 | Store access request, held until done |
| mem_we_o | output | 1 | 1 = store write, 0 = fetch |
| mem_idx_o | output | 2 | Channel addressed in the store |
| mem_wdata_o | output | 7 | Value to write to the store |
| mem_rdata_i | input | 7 | Fetched value, valid with done |
| mem_done_i | input | 1 | Store access complete |
| wiper_o | output | 4x7 | Wiper positions, channel 0 in the low element |

## Verification
Tap writes, STOP handling and fetch results all land one clock edge after the cycle that presents them. The busy flag rises on the edge that samples STOP and falls BUSY_CYCLES edges later. Read data follows the read address with no register delay. The bench keeps a per-cycle behavioural model that it advances on each rising edge. It compares every wiper output and the read data two nanoseconds after that edge, and it takes its directed checks at the following falling edge, so every sample falls after the edge that is due to update it.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SQ_RECALL = 2'd0,
    SQ_IDLE   = 2'd1,
    SQ_BUSY   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? CNT_W'(BUSY_CYCLES - 1) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int unsigned CH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_i,
  input  logic                  pend_valid_i,
  input  logic                  mem_done_i,
  input  logic                  tmr_zero_i,
  output logic                  stop_go_o,
  output logic                  commit_o,
  output logic                  recall_load_o,
  output logic [$clog2(CH)-1:0] rptr_o,
  output logic                  ready_o,
  output logic                  wip_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o
);
  localparam int unsigned CH_W = $clog2(CH);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] rptr_q, rptr_d;
  logic            stored_q, stored_d;

  always_comb begin
    state_d       = state_q;
    rptr_d        = rptr_q;
    stored_d      = stored_q;
    stop_go_o     = 1'b0;
    commit_o      = 1'b0;
    recall_load_o = 1'b0;
    mem_req_o     = 1'b0;
    mem_we_o      = 1'b0;
    case (state_q)
      SQ_RECALL: begin
        mem_req_o = 1'b1;
        if (mem_done_i) begin
          recall_load_o = 1'b1;
          rptr_d        = rptr_q + 1'b1;
          if (rptr_q == CH_W'(CH - 1)) state_d = SQ_IDLE;
        end
      end
      SQ_IDLE: begin
        if (stop_i && pend_valid_i) begin
          stop_go_o = 1'b1;
          stored_d  = 1'b0;
          state_d   = SQ_BUSY;
        end
      end
      SQ_BUSY: begin
        mem_we_o  = 1'b1;
        mem_req_o = !stored_q;
        if (!stored_q && mem_done_i) stored_d = 1'b1;
        if (tmr_zero_i && (stored_q || mem_done_i)) begin
          commit_o = 1'b1;
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_RECALL;
      rptr_q   <= '0;
      stored_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rptr_q   <= rptr_d;
      stored_q <= stored_d;
    end
  end

  assign rptr_o  = rptr_q;
  assign ready_o = (state_q != SQ_RECALL);
  assign wip_o   = (state_q == SQ_BUSY);
endmodule

// File: rtl/nvs_regfile.sv
module nvs_regfile #(
  parameter int unsigned CH      = 4,
  parameter int unsigned TAP_W   = 7,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WIP_BIT = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ready_i,
  input  logic                          wip_i,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          recall_load_i,
  input  logic [$clog2(CH)-1:0]         recall_idx_i,
  input  logic [TAP_W-1:0]              recall_data_i,
  input  logic                          stop_go_i,
  input  logic                          commit_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          pend_valid_o,
  output logic [$clog2(CH)-1:0]         pend_idx_o,
  output logic [TAP_W-1:0]              pend_data_o,
  output logic [CH-1:0][TAP_W-1:0]      tap_o
);
  localparam int unsigned CH_W   = $clog2(CH);
  localparam int unsigned CTRL_A = 2 * CH;

  logic [CH-1:0][TAP_W-1:0] tap_q, shadow_q;
  logic [TAP_W-1:0]         wval;
  logic [CH_W-1:0]          widx, ridx;
  logic                     is_tap, is_ivr, accept_ivr;
  logic                     pend_valid_q, pend_valid_d, pend_en;
  logic [CH_W-1:0]          pend_idx_q;
  logic [TAP_W-1:0]         pend_data_q;
  logic                     unused_hi;

  assign unused_hi = ^wr_data_i[DATA_W-1:TAP_W];
  assign wval      = wr_data_i[TAP_W-1:0];
  assign widx      = wr_addr_i[CH_W-1:0];
  assign ridx      = rd_addr_i[CH_W-1:0];

  always_comb begin
    is_tap       = (wr_addr_i < ADDR_W'(CH));
    is_ivr       = (wr_addr_i >= ADDR_W'(CH)) && (wr_addr_i < ADDR_W'(CTRL_A));
    accept_ivr   = wr_en_i && is_ivr && ready_i && !wip_i && !pend_valid_q;
    pend_en      = stop_go_i || accept_ivr;
    pend_valid_d = accept_ivr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_idx_q   <= '0;
      pend_data_q  <= '0;
    end else if (pend_en) begin
      pend_valid_q <= pend_valid_d;
      if (accept_ivr) begin
        pend_idx_q  <= widx;
        pend_data_q <= wval;
      end
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_chan
    logic             hit_rc, hit_wr, hit_cm;
    logic [TAP_W-1:0] tap_d, shd_d;

    always_comb begin
      hit_rc = recall_load_i && (recall_idx_i == CH_W'(g));
      hit_wr = ready_i && wr_en_i && (widx == CH_W'(g)) && (is_tap || accept_ivr);
      hit_cm = commit_i && (pend_idx_q == CH_W'(g));
      tap_d  = hit_rc ? recall_data_i : wval;
      shd_d  = hit_rc ? recall_data_i : pend_data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tap_q[g] <= '0;
      else if (hit_rc || hit_wr) tap_q[g] <= tap_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                shadow_q[g] <= '0;
      else if (hit_rc || hit_cm) shadow_q[g] <= shd_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(CH))
      rd_data_o = DATA_W'(tap_q[ridx]);
    else if (rd_addr_i < ADDR_W'(CTRL_A))
      rd_data_o = DATA_W'(shadow_q[ridx]);
    else if (rd_addr_i == ADDR_W'(CTRL_A))
      rd_data_o[WIP_BIT] = wip_i;
  end

  assign pend_valid_o = pend_valid_q;
  assign pend_idx_o   = pend_idx_q;
  assign pend_data_o  = pend_data_q;
  assign tap_o        = tap_q;
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl #(
  parameter int unsigned CH          = 4,
  parameter int unsigned TAP_W       = 7,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WIP_BIT     = 5,
  parameter int unsigned BUSY_CYCLES = 2500000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     stop_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [$clog2(CH)-1:0]    mem_idx_o,
  output logic [TAP_W-1:0]         mem_wdata_o,
  input  logic [TAP_W-1:0]         mem_rdata_i,
  input  logic                     mem_done_i,
  output logic [CH-1:0][TAP_W-1:0] wiper_o
);
  localparam int unsigned CH_W = $clog2(CH);
  localparam logic [TAP_W-1:0] MID = TAP_W'(1) << (TAP_W - 1);

  logic                     ready, wip, tmr_zero;
  logic                     stop_go, commit, recall_load, pend_valid;
  logic [CH_W-1:0]          rptr, pend_idx;
  logic [TAP_W-1:0]         pend_data;
  logic [CH-1:0][TAP_W-1:0] tap;

  nvs_sequencer #(.CH(CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pend_valid_i(pend_valid),
    .mem_done_i(mem_done_i), .tmr_zero_i(tmr_zero), .stop_go_o(stop_go),
    .commit_o(commit), .recall_load_o(recall_load), .rptr_o(rptr),
    .ready_o(ready), .wip_o(wip), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o)
  );

  nvs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(stop_go), .zero_o(tmr_zero)
  );

  nvs_regfile #(
    .CH(CH), .TAP_W(TAP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIP_BIT(WIP_BIT)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .wip_i(wip),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .recall_load_i(recall_load), .recall_idx_i(rptr), .recall_data_i(mem_rdata_i),
    .stop_go_i(stop_go), .commit_i(commit), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .pend_valid_o(pend_valid), .pend_idx_o(pend_idx),
    .pend_data_o(pend_data), .tap_o(tap)
  );

  assign mem_idx_o   = ready ? pend_idx : rptr;
  assign mem_wdata_o = pend_data;

  for (genvar g = 0; g < CH; g++) begin : g_out
    assign wiper_o[g] = ready ? tap[g] : MID;
  end
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk #(
  parameter int unsigned CH     = 4,
  parameter int unsigned TAP_W  = 7,
  parameter int unsigned ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     stop_i,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        wr_addr_i,
  input logic                     wip,
  input logic                     ready,
  input logic                     tmr_zero,
  input logic                     mem_req_o,
  input logic                     mem_we_o,
  input logic                     mem_done_i,
  input logic [CH-1:0][TAP_W-1:0] wiper_o
);
  logic ivr_wr;
  assign ivr_wr = wr_en_i && (wr_addr_i >= ADDR_W'(CH)) && (wr_addr_i < ADDR_W'(2 * CH));

  // R5
  wip_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(stop_i));

  // R5
  store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> wip);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !tmr_zero) |=> wip);

  // R1
  ready_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(mem_done_i));

  // R7
  busy_ivr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && ivr_wr) |=> $stable(wiper_o));
endmodule

bind nvs_ctrl nvs_ctrl_chk #(.CH(CH), .TAP_W(TAP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wip(wip), .ready(ready), .tmr_zero(tmr_zero),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_done_i(mem_done_i),
  .wiper_o(wiper_o)
);

// File: tb/tb_nvs_ctrl.sv
module tb_nvs_ctrl;
  localparam int B = 20;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en, stop;
  logic [3:0]      wr_addr, rd_addr;
  logic [7:0]      wr_data, rd_data;
  logic            mem_req, mem_we, mem_done;
  logic [1:0]      mem_idx;
  logic [6:0]      mem_wdata, mem_rdata;
  logic [3:0][6:0] wiper;
  logic [6:0]      nv [4];

  int checks = 0, fails = 0;
  int rcnt, wip_left, pend, pidx, pdat, wprev, pprev;
  int mw [4];
  int ms [4];

  always #4 clk = ~clk;

  nvs_ctrl #(.BUSY_CYCLES(B)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .stop_i(stop), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_idx_o(mem_idx),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_done_i(mem_done),
    .wiper_o(wiper)
  );

  // store model: answers in the same cycle it is asked
  assign mem_done  = mem_req;
  assign mem_rdata = nv[mem_idx];
  always @(posedge clk) if (rst_n && mem_req && mem_we) nv[mem_idx] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; wip_left = 0; pend = 0;
      for (int i = 0; i < 4; i++) begin mw[i] = 0; ms[i] = 0; end
    end else if (rcnt < 4) begin
      mw[rcnt] = nv[rcnt]; ms[rcnt] = nv[rcnt]; rcnt++;
    end else begin
      wprev = (wip_left > 0); pprev = pend;
      if (wip_left > 0) begin
        wip_left--;
        if (wip_left == 0) ms[pidx] = pdat;
      end
      if (wr_en) begin
        if (wr_addr < 4) mw[wr_addr] = wr_data[6:0];
        else if (wr_addr < 8 && !wprev && !pprev) begin
          mw[wr_addr-4] = wr_data[6:0];
          pend = 1; pidx = wr_addr - 4; pdat = wr_data[6:0];
        end
      end
      if (stop && pprev && !wprev) begin pend = 0; wip_left = B; end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    int e;
    #2;
    for (int i = 0; i < 4; i++)
      chk((rcnt < 4) ? "R2 wiper" : "R3 wiper", 32'(wiper[i]), (rcnt < 4) ? 64 : mw[i]);
    if (rd_addr < 4) e = mw[rd_addr];
    else if (rd_addr < 8) e = ms[rd_addr-4];
    else if (rd_addr == 8) e = (wip_left > 0) ? 32 : 0;
    else e = 0;
    chk("R6 readback", 32'(rd_data), e);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic stp();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 4'(a); #1; v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    int v;
    for (int k = 0; k < 100; k++) begin
      rd(8, v);
      if (v == 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int v, n;
    nv[0] = 7'd10; nv[1] = 7'd20; nv[2] = 7'd30; nv[3] = 7'd40;
    rst_n = 1'b0; wr_en = 1'b0; stop = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = 4'd8;
    repeat (3) @(negedge clk);
    chk("R2 reset mid-scale", 32'(wiper[2]), 64);
    rst_n = 1'b1;
    // R11: write during fetch
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'd7;
    @(negedge clk); wr_en = 1'b0;
    chk("R2 mid-scale during fetch", 32'(wiper[0]), 64);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R1 fetched value", 32'(wiper[i]), 32'(nv[i]));
    chk("R11 write during fetch ignored", 32'(wiper[0]), 10);

    wr(1, 8'hFF);
    chk("R3 tap write low bits", 32'(wiper[1]), 127);
    wr(0, 33);
    chk("R3 tap write", 32'(wiper[0]), 33);

    wr(6, 99);
    chk("R4 ivr write moves wiper", 32'(wiper[2]), 99);
    rd(6, v); chk("R4 stored copy unchanged", v, 30);
    wr(4, 5);
    chk("R7 second pending ignored", 32'(wiper[0]), 33);
    repeat (30) @(negedge clk);
    rd(8, v); chk("R5 no commit without STOP", v, 0);
    chk("R5 store untouched before STOP", 32'(nv[2]), 30);
    stp();
    n = 0;
    for (int k = 0; k < 100; k++) begin
      rd(8, v);
      if (v != 32) break;
      n++;
      @(negedge clk);
    end
    chk("R6 busy window length", n, B);
    rd(6, v); chk("R8 committed value after busy", v, 99);
    rd(4, v); chk("R7 dropped pending left copy", v, 10);
    chk("R5 store written", 32'(nv[2]), 99);

    wr(5, 77);
    stp();
    rd(8, v); chk("R6 busy flag bit 5", v, 32);
    rd(5, v); chk("R8 old value while busy", v, 20);
    wr(7, 88);
    chk("R7 ivr write while busy ignored", 32'(wiper[3]), 40);
    wr(0, 11);
    chk("R3 tap write while busy", 32'(wiper[0]), 11);
    wait_idle();
    rd(5, v); chk("R8 new value after busy", v, 77);
    rd(7, v); chk("R7 busy write left copy", v, 40);

    stp();
    rd(8, v); chk("R5 STOP without pending", v, 0);
    wr(8, 8'hFF);
    rd(8, v); chk("R10 ctrl write ignored", v, 0);
    wr(12, 8'h55);
    rd(12, v); chk("R10 unused address", v, 0);
    chk("R10 unused write no tap change", 32'(wiper[0]), 11);

    do_reset();
    repeat (6) @(negedge clk);
    chk("R9 ch0 after reset", 32'(wiper[0]), 10);
    chk("R9 ch1 after reset", 32'(wiper[1]), 77);
    chk("R9 ch2 after reset", 32'(wiper[2]), 99);
    chk("R9 ch3 after reset", 32'(wiper[3]), 40);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule